// File: doc/BRIEF.md
# Receive Frame Status Queue

This block sits beside a bit-oriented (HDLC-style) serial receiver and keeps a record of every frame that ends. A 14-bit byte counter follows the length of the frame being received. It clears when a flag is detected and steps once for each received byte. When the receiver signals end of frame, the counter value is stored in a ten-entry queue together with the frame's residue bits, overrun flag and CRC error flag. Software can therefore let several short frames arrive back to back and collect their lengths and error status later.

The host sees three read registers: a status byte, a low count byte and a high count byte. The high count byte also carries a data-available flag and a sticky overflow flag. While the queue is operating and holds at least one entry, the count and the error/residue fields come from the oldest entry, and the end-of-frame bit reads as 1. Otherwise every field shows the live receiver status and the live counter. An entry is retired only when the host reads the status byte and then reads the high count byte, so the fields it has read all belong to one frame.

Top module: `rx_frame_status_fifo`

## Requirements
- R1: The queue operates only while `queueEnable` and `hdlcMode` are both 1. In any cycle where either is 0, the outputs show the live view with bits 7 and 6 of `countHiReg` at 0, and at the next clock edge the queue is emptied, the overflow flag is cleared and any pending status read is forgotten.
- R2: The byte counter is 14 bits wide and is visible in the live view as `countHiReg[5:0]` (upper six bits) and `countLoReg` (lower eight bits). A `flagDet` clears it to 0 and takes priority over `byteDet`. Otherwise a `byteDet` with `hdlcMode`=1 adds one, wrapping from 16383 to 0. A `byteDet` with `hdlcMode`=0 leaves it unchanged.
- R3: While operating, an `eofStrobe` with fewer than 10 stored entries appends one entry. The entry holds the counter value from before that clock edge, together with `liveResidue`, `liveOverrun` and `liveCrcErr` from that cycle. Entries leave the queue in arrival order.
- R4: While operating, an `eofStrobe` that arrives with 10 stored entries discards that frame's status and sets `countHiReg[7]`. That bit stays 1 until the block stops operating or is reset.
- R5: `countHiReg[6]` is 1 exactly when the block is operating and the queue is not empty. While the queue is empty the outputs show the live view.
- R6: The oldest entry is removed at the clock edge of a cycle with `rdCountHi`=1, provided an earlier cycle had `rdStatus`=1 and no `rdCountHi` has occurred since then. A `rdCountHi` that does not follow a `rdStatus` removes nothing, and a `rdStatus` on its own removes nothing.
- R7: Layout of the read registers. `statusReg` bit 7 is end of frame, bit 6 is CRC error, bit 5 is overrun and bits 4:2 are residue. `countLoReg` holds count bits 7:0. `countHiReg[5:0]` holds count bits 13:8. When these fields come from the queue, `statusReg[7]` reads as 1.
- R8: `statusReg[0]` always equals `liveAllSent` and `statusReg[1]` always equals `liveParityErr`, whether or not the other fields come from the queue.
- R9: A removal and an append can happen in the same cycle. When that cycle starts with 10 entries, the new frame is discarded and the overflow flag is set, because fullness is judged before the removal.
- R10: After reset the queue is empty, the overflow flag is 0, no status read is pending and the byte counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| queueEnable | input | 1 | Configuration bit that allows the queue to operate |
| hdlcMode | input | 1 | Receiver is in bit-oriented framing mode |
| byteDet | input | 1 | One received byte (strobe) |
| flagDet | input | 1 | Flag sequence detected (strobe) |
| eofStrobe | input | 1 | End of frame detected (strobe) |
| liveResidue | input | 3 | Live residue bits of the receiver |
| liveOverrun | input | 1 | Live receive overrun flag |
| liveCrcErr | input | 1 | Live CRC error flag |
| liveEndFrame | input | 1 | Live end-of-frame status bit |
| liveAllSent | input | 1 | Live all-sent status bit |
| liveParityErr | input | 1 | Live parity error bit |
| rdStatus | input | 1 | Host read of the status byte (strobe) |
| rdCountHi | input | 1 | Host read of the high count byte (strobe) |
| statusReg | output | 8 | Status byte seen by the host |
| countLoReg | output | 8 | Low count byte |
| countHiReg | output | 8 | Overflow, data-available and high count bits |

## Verification
The bench drives a ten-frame burst with no reads and follows it with more end-of-frame strobes. A queue that is off by one in depth, or one that overwrites the oldest entry instead of dropping the newest, shows a wrong count or a missing overflow bit as soon as the host starts reading. Stretches of high-byte reads with no status read catch a design that removes entries without the read pairing. Heavy phases where reads and frame ends overlap catch a design that judges fullness after the removal. A run of more than 16384 bytes checks the counter wrap. Random toggling of the enable and mode inputs checks that the queue is flushed and the bypass view shown, and that the all-sent and parity bits never come from a stored entry.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  localparam int COUNT_W = 14;
  localparam int RESID_W = 3;
  localparam int STAT_W  = RESID_W + 2;

  typedef struct packed {
    logic               crcErr;
    logic               overrun;
    logic [RESID_W-1:0] residue;
  } frame_stat_t;

  typedef struct packed {
    logic [COUNT_W-1:0] byteCount;
    frame_stat_t        stat;
  } fifo_entry_t;

  typedef struct packed {
    logic flush;
    logic write;
    logic showHead;
  } ctrl_strobe_t;
endpackage

// File: rtl/fsf_control.sv
module fsf_control
  import fsf_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              active,
  input  logic              eofStrobe,
  input  logic              rdStatus,
  input  logic              rdCountHi,
  output ctrl_strobe_t      strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              availFlag,
  output logic              overflowFlag
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   DEPTH_OCC = (ADDR_W + 1)'(DEPTH);

  logic [ADDR_W-1:0] headAddr, tailAddr;
  logic              headLap, tailLap;
  logic              armed, overflowReg;
  logic              addrEqual, empty, full, doPush, doPop, pushDenied;
  logic [ADDR_W:0]   occupancy;

  // pointer comparator: same slot, same lap -> empty; same slot, other lap -> full
  assign addrEqual  = (headAddr == tailAddr);
  assign empty      = addrEqual && (headLap == tailLap);
  assign full       = addrEqual && (headLap != tailLap);
  assign doPush     = active && eofStrobe && !full;
  assign pushDenied = active && eofStrobe && full;
  assign doPop      = active && rdCountHi && armed && !empty;

  always_comb begin
    if (headLap == tailLap) occupancy = (ADDR_W + 1)'(tailAddr) - (ADDR_W + 1)'(headAddr);
    else occupancy = DEPTH_OCC - (ADDR_W + 1)'(headAddr) + (ADDR_W + 1)'(tailAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      headAddr    <= '0;
      tailAddr    <= '0;
      headLap     <= 1'b0;
      tailLap     <= 1'b0;
      armed       <= 1'b0;
      overflowReg <= 1'b0;
    end else begin
      if (doPush) begin
        if (tailAddr == LAST_ADDR) begin
          tailAddr <= '0;
          tailLap  <= !tailLap;
        end else begin
          tailAddr <= tailAddr + 1'b1;
        end
      end
      if (doPop) begin
        if (headAddr == LAST_ADDR) begin
          headAddr <= '0;
          headLap  <= !headLap;
        end else begin
          headAddr <= headAddr + 1'b1;
        end
      end
      if (pushDenied) overflowReg <= 1'b1;
      if (rdStatus) armed <= 1'b1;
      else if (rdCountHi) armed <= 1'b0;
    end
  end

  assign strobes.flush    = !active;
  assign strobes.write    = doPush;
  assign strobes.showHead = active && !empty;
  assign wrAddr           = tailAddr;
  assign rdAddr           = headAddr;
  assign availFlag        = active && !empty;
  assign overflowFlag     = active && overflowReg;

  p_flush_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (occupancy == '0) && !overflowReg && !armed);
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= DEPTH_OCC);
  p_set_when_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && eofStrobe && (occupancy == DEPTH_OCC)) |=> overflowReg);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (active && $past(active) && $past(overflowReg)) |-> overflowReg);
  p_no_pop_unarmed_r6: assert property (@(posedge clk) disable iff (!rstN)
    (active && !armed && !eofStrobe) |=> (occupancy == $past(occupancy)));
endmodule

// File: rtl/fsf_datapath.sv
module fsf_datapath
  import fsf_pkg::*;
#(
  parameter int DEPTH  = 10,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  logic               hdlcMode,
  input  logic               byteDet,
  input  logic               flagDet,
  input  frame_stat_t        liveStat,
  input  logic               liveEndFrame,
  output logic [COUNT_W-1:0] viewCount,
  output frame_stat_t        viewStat,
  output logic               viewEndFrame
);
  logic [COUNT_W-1:0] byteCount;
  fifo_entry_t        slot [DEPTH];
  fifo_entry_t        headEntry;

  // frame length counter
  always_ff @(posedge clk) begin
    if (!rstN || flagDet) byteCount <= '0;
    else if (byteDet && hdlcMode) byteCount <= byteCount + 1'b1;
  end

  // storage slots, one register per entry
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) slot[gi] <= '0;
      else if (strobes.write && (wrAddr == ADDR_W'(gi))) begin
        slot[gi].byteCount <= byteCount;
        slot[gi].stat      <= liveStat;
      end
    end
  end

  always_comb begin
    headEntry = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdAddr == ADDR_W'(i)) headEntry = slot[i];
    end
  end

  // view mux: head entry or live status
  always_comb begin
    if (strobes.showHead) begin
      viewCount    = headEntry.byteCount;
      viewStat     = headEntry.stat;
      viewEndFrame = 1'b1;
    end else begin
      viewCount    = byteCount;
      viewStat     = liveStat;
      viewEndFrame = liveEndFrame;
    end
  end

  p_count_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    flagDet |=> (byteCount == '0));
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flagDet && byteDet && hdlcMode) |=> (byteCount == $past(byteCount) + 1'b1));
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!flagDet && !(byteDet && hdlcMode)) |=> $stable(byteCount));
endmodule

// File: rtl/rx_frame_status_fifo.sv
module rx_frame_status_fifo
  import fsf_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               queueEnable,
  input  logic               hdlcMode,
  input  logic               byteDet,
  input  logic               flagDet,
  input  logic               eofStrobe,
  input  logic [RESID_W-1:0] liveResidue,
  input  logic               liveOverrun,
  input  logic               liveCrcErr,
  input  logic               liveEndFrame,
  input  logic               liveAllSent,
  input  logic               liveParityErr,
  input  logic               rdStatus,
  input  logic               rdCountHi,
  output logic [7:0]         statusReg,
  output logic [7:0]         countLoReg,
  output logic [7:0]         countHiReg
);
  localparam int ADDR_W = $clog2(DEPTH);

  ctrl_strobe_t       strobes;
  logic [ADDR_W-1:0]  wrAddr, rdAddr;
  logic               availFlag, overflowFlag, active, viewEndFrame;
  logic [COUNT_W-1:0] viewCount;
  frame_stat_t        liveStat, viewStat;
  logic [5:0]         hiBits;

  assign active   = queueEnable && hdlcMode;
  assign liveStat = '{crcErr: liveCrcErr, overrun: liveOverrun, residue: liveResidue};

  fsf_control #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) ctrl_i (
    .clk, .rstN, .active, .eofStrobe, .rdStatus, .rdCountHi,
    .strobes, .wrAddr, .rdAddr, .availFlag, .overflowFlag
  );

  fsf_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) data_i (
    .clk, .rstN, .strobes, .wrAddr, .rdAddr, .hdlcMode, .byteDet, .flagDet,
    .liveStat, .liveEndFrame, .viewCount, .viewStat, .viewEndFrame
  );

  assign hiBits     = 6'(viewCount >> 8);
  assign statusReg  = {viewEndFrame, viewStat.crcErr, viewStat.overrun, viewStat.residue,
                       liveParityErr, liveAllSent};
  assign countLoReg = viewCount[7:0];
  assign countHiReg = {overflowFlag, availFlag, hiBits};

  p_eof_from_queue_r7: assert property (@(posedge clk) disable iff (!rstN)
    availFlag |-> statusReg[7]);
  p_off_flags_r1: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> (countHiReg[7:6] == 2'b00));
endmodule

// File: tb/rx_frame_status_fifo_tb_top.sv
module rx_frame_status_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic queueEnable = 1'b0, hdlcMode = 1'b0, byteDet = 1'b0, flagDet = 1'b0, eofStrobe = 1'b0;
  logic [2:0] liveResidue = '0;
  logic liveOverrun = 1'b0, liveCrcErr = 1'b0, liveEndFrame = 1'b0;
  logic liveAllSent = 1'b0, liveParityErr = 1'b0, rdStatus = 1'b0, rdCountHi = 1'b0;
  logic [7:0] statusReg, countLoReg, countHiReg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  int mCount = 0;
  int qCnt[$];
  int qSt[$];
  bit mOvf = 0, mArmed = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_frame_status_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk, .rstN, .queueEnable, .hdlcMode, .byteDet, .flagDet, .eofStrobe,
    .liveResidue, .liveOverrun, .liveCrcErr, .liveEndFrame, .liveAllSent,
    .liveParityErr, .rdStatus, .rdCountHi, .statusReg, .countLoReg, .countHiReg
  );

  task automatic chk(string req, string phase, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  task automatic compareAll(string phase);
    bit act, showF;
    int eCnt, eSt, eEof, eStatus, eHi;
    act   = queueEnable && hdlcMode;
    showF = act && (qCnt.size() > 0);
    eCnt  = showF ? qCnt[0] : mCount;
    eSt   = showF ? qSt[0] : {liveCrcErr, liveOverrun, liveResidue};
    eEof  = showF ? 1 : int'(liveEndFrame);
    eStatus = (eEof << 7) | (eSt << 2) | (int'(liveParityErr) << 1) | int'(liveAllSent);
    eHi   = (int'(act && mOvf) << 7) | (int'(showF) << 6) | ((eCnt >> 8) & 63);
    chk("R8", phase, int'(statusReg[1:0]), eStatus & 3);
    chk("R7", phase, int'(statusReg[7:2]), eStatus >> 2);
    chk("R7", phase, int'(countLoReg), eCnt & 255);
    chk("R2", phase, int'(countHiReg[5:0]), eHi & 63);
    chk("R5", phase, int'(countHiReg[6]), (eHi >> 6) & 1);
    chk("R4", phase, int'(countHiReg[7]), (eHi >> 7) & 1);
  endtask

  task automatic modelStep();
    bit act, full;
    act  = queueEnable && hdlcMode;
    full = (qCnt.size() == DEPTH);
    if (!act) begin
      qCnt.delete(); qSt.delete(); mOvf = 0; mArmed = 0;
    end else begin
      if (rdCountHi && mArmed && qCnt.size() > 0) begin
        void'(qCnt.pop_front()); void'(qSt.pop_front());
      end
      if (eofStrobe) begin
        if (full) mOvf = 1;
        else begin
          qCnt.push_back(mCount);
          qSt.push_back({liveCrcErr, liveOverrun, liveResidue});
        end
      end
      if (rdStatus) mArmed = 1;
      else if (rdCountHi) mArmed = 0;
    end
    if (flagDet) mCount = 0;
    else if (byteDet && hdlcMode) mCount = (mCount + 1) & 16383;
  endtask

  function automatic bit pick(int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic runPhase(string phase, int n, int pEn, int pMode, int pBd, int pFd,
                          int pEof, int pRs, int pRh);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      queueEnable = pick(pEn); hdlcMode = pick(pMode);
      byteDet = pick(pBd); flagDet = pick(pFd); eofStrobe = pick(pEof);
      rdStatus = pick(pRs); rdCountHi = pick(pRh);
      liveResidue = 3'($urandom); liveOverrun = pick(50); liveCrcErr = pick(50);
      liveEndFrame = pick(50); liveAllSent = pick(50); liveParityErr = pick(50);
      #1 compareAll(phase);
      @(posedge clk);
      modelStep();
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1; queueEnable = 1'b1; hdlcMode = 1'b1;
    #1;
    // R10: reset state, live view with zero count
    chk("R10", "reset", int'(countHiReg), 0);
    chk("R10", "reset", int'(countLoReg), 0);
    chk("R10", "reset", int'(statusReg), 0);
    // R3 fill with no reads, then keep ending frames to overflow (R4)
    runPhase("R3", 400, 100, 100, 60, 5, 8, 0, 0);
    // R6: high-byte reads without status reads must not retire entries
    runPhase("R6", 300, 100, 100, 50, 5, 5, 0, 40);
    // drain with paired reads
    runPhase("R6", 300, 100, 100, 30, 5, 3, 50, 50);
    // R9: dense overlapping reads and frame ends, including at full
    runPhase("R9", 3000, 100, 100, 50, 5, 15, 30, 30);
    // R1: enable and mode toggling
    runPhase("R1", 3000, 90, 95, 50, 5, 10, 30, 30);
    // R8: mode off, counter frozen, live view only
    runPhase("R8", 300, 100, 0, 60, 2, 10, 30, 30);
    // R2: long run across the 14-bit wrap, then capture lengths
    runPhase("R2", 16500, 100, 100, 100, 0, 0, 0, 0);
    runPhase("R2", 400, 100, 100, 50, 1, 10, 40, 40);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule